// File: doc/BRIEF.md
# Strided Banked Vector Loader

This block streams one vector load from an interleaved memory of several banks into a vector register. A command carries a start address, a signed step (stride) and an element count. The block produces one element address per element, equal to the start plus the element number times the step. It sends these to the memory in element order, at most one per cycle. The low address bits select the bank and the remaining bits select the row inside that bank.

Each bank stays occupied for a fixed number of cycles after it takes a request. The block holds back the next request while its bank is occupied and never reorders requests. The memory returns read data a fixed number of cycles after each request. The block therefore knows, without any response handshake, which cycle carries the data for which element. It writes that data into the destination register at the element's index and pulses a completion flag one cycle after the last write. The achieved rate depends on the stride: a step of one gives one element per cycle, and a step that lands on the same bank every time gives one element per bank-occupancy period.

Top module: `vec_stride_loader`

## Requirements
- R1: `cmd_ready` is high exactly when no load is in progress. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. A `cmd_valid` during a load has no effect on the requests, writes or completion of that load.
- R2: Element i uses the address `cmd_base + i*cmd_stride` modulo 2^ADDR_W. It is presented as `mem_req_bank` = address bits [3:0] and `mem_req_row` = address bits [ADDR_W-1:4].
- R3: Requests leave in strictly increasing element order, at most one per cycle. The first request can appear in the cycle after the command is taken, and a request appears in every cycle in which the next element's bank is free.
- R4: A bank that takes a request in cycle k takes no request in cycles k+1 to k+3. While the next element's bank is occupied, `mem_req_valid` stays low. A unit stride therefore gives one request per cycle, and a stride that is a multiple of 16 gives one request every 4 cycles.
- R5: The data for a request issued in cycle k is taken from `mem_rd_data` in cycle k+12. In that same cycle it is written with `vreg_we` high, `vreg_idx` equal to the element number and `vreg_data` equal to that data, so writes follow element order.
- R6: `done` is high for one cycle, in the cycle after the final element's write.
- R7: A command with a count of zero makes no request and no write, and raises `done` in the cycle after it is taken.
- R8: A count larger than MAX_VL (64) is treated as MAX_VL.
- R9: While reset is held and after it is released, `cmd_ready` is high and `mem_req_valid`, `vreg_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Load command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | ADDR_W | Start word address |
| cmd_stride | input | ADDR_W | Signed address step between elements |
| cmd_vlen | input | LEN_W | Number of elements, clamped to MAX_VL |
| mem_req_valid | output | 1 | Read request this cycle |
| mem_req_bank | output | BANK_W | Bank of the requested word |
| mem_req_row | output | ADDR_W-BANK_W | Row of the requested word within its bank |
| mem_rd_data | input | DATA_W | Read data, valid MEM_LAT cycles after the request |
| vreg_we | output | 1 | Vector register element write |
| vreg_idx | output | IDX_W | Element index being written |
| vreg_data | output | DATA_W | Element data being written |
| done | output | 1 | Load complete pulse |

## Verification
A bank timer that is wrong shows at `mem_req_valid` at once. It either sends a request early, in the cycle it should stall, or stalls in a cycle where a request is due. A wrong address or count register shows on the bank and row outputs at the next request. A fault in the latency pipeline shows twelve cycles later as a misplaced `vreg_we`, a wrong index or data taken from the wrong cycle. A fault in the write counter shows as `done` arriving early, late or never. The reference model is compared with the outputs in every cycle, so each of these faults is reported in the first cycle in which it is visible.

// File: rtl/vsl_pkg.sv
package vsl_pkg;

  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;

  // Limit a requested element count to the register capacity.
  function automatic int unsigned fit_len(input int unsigned want, input int unsigned cap);
    return (want > cap) ? cap : want;
  endfunction

endpackage

// File: rtl/vsl_bank_timers.sv
module vsl_bank_timers #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY      = 4,
  parameter int BANK_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 claim_valid,
  input  logic [BANK_W-1:0]    claim_bank,
  output logic [NUM_BANKS-1:0] busy_vec
);

  localparam int TW = (BUSY < 2) ? 1 : $clog2(BUSY + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        left_q <= '0;
      end else if (claim_valid && claim_bank == BANK_W'(b)) begin
        left_q <= TW'(BUSY - 1);
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end

    assign busy_vec[b] = (left_q != '0);
  end

  // R4: the issuer may only claim a bank whose timer has run out
  p_claim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |-> !busy_vec[claim_bank]);

  if (BUSY > 1) begin : g_busy_chk
    // R4: a claimed bank reports occupied on the following cycle
    p_busy_after_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      claim_valid |=> busy_vec[$past(claim_bank)]);
  end

endmodule

// File: rtl/vsl_return_track.sv
module vsl_return_track #(
  parameter int MEM_LAT = 12,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [IDX_W-1:0] push_idx,
  output logic             pop_valid,
  output logic [IDX_W-1:0] pop_idx
);

  logic             v_q   [MEM_LAT];
  logic [IDX_W-1:0] idx_q [MEM_LAT];

  for (genvar s = 0; s < MEM_LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[0]   <= 1'b0;
          idx_q[0] <= '0;
        end else begin
          v_q[0]   <= push_valid;
          idx_q[0] <= push_idx;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[s]   <= 1'b0;
          idx_q[s] <= '0;
        end else begin
          v_q[s]   <= v_q[s-1];
          idx_q[s] <= idx_q[s-1];
        end
      end
    end
  end

  assign pop_valid = v_q[MEM_LAT-1];
  assign pop_idx   = idx_q[MEM_LAT-1];

endmodule

// File: rtl/vsl_addr_gen.sv
module vsl_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int MAX_VL    = 64,
  parameter int LEN_W     = 7,
  parameter int IDX_W     = 6,
  parameter int BANK_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [ADDR_W-1:0]    cmd_base,
  input  logic [ADDR_W-1:0]    cmd_stride,
  input  logic [LEN_W-1:0]     cmd_vlen,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic                 wr_fire,
  input  logic [IDX_W-1:0]     wr_idx,
  output logic                 idle,
  output logic                 req_valid,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [IDX_W-1:0]     req_idx,
  output logic                 done
);

  import vsl_pkg::*;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] s);
    return a + s;
  endfunction

  ld_state_e          state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W-1:0]  stride_q;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   iss_q;
  logic [LEN_W-1:0]   wrc_q;
  logic               done_q;
  logic [LEN_W-1:0]   vlen_fit;
  logic               accept;
  logic               more;
  logic               last_wr;

  assign vlen_fit  = LEN_W'(fit_len(int'(cmd_vlen), MAX_VL));
  assign idle      = (state_q == LD_IDLE);
  assign accept    = cmd_valid && idle;
  assign more      = (iss_q < len_q);
  assign req_valid = (state_q == LD_RUN) && more && !bank_busy[bank_of(addr_q)];
  assign req_addr  = addr_q;
  assign req_idx   = iss_q[IDX_W-1:0];
  assign last_wr   = wr_fire && (wrc_q == len_q - 1'b1);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= LD_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      iss_q    <= '0;
      wrc_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (vlen_fit == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q  <= LD_RUN;
          addr_q   <= cmd_base;
          stride_q <= cmd_stride;
          len_q    <= vlen_fit;
          iss_q    <= '0;
          wrc_q    <= '0;
        end
      end else if (state_q == LD_RUN) begin
        if (req_valid) begin
          addr_q <= addr_step(addr_q, stride_q);
          iss_q  <= iss_q + 1'b1;
        end
        if (wr_fire) begin
          wrc_q <= wrc_q + 1'b1;
        end
        if (last_wr) begin
          state_q <= LD_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  // R1: no request leaves while idle
  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !req_valid);

  // R1: a command offered during a load leaves the load length untouched
  p_busy_ignores_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd_valid) |=> $stable(len_q));

  // R5: returning data arrives for the element the write counter expects
  p_write_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_idx == wrc_q[IDX_W-1:0]));

  // R6: completion is signalled only with the block back in idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);

  // R8: issue count never runs past the register capacity
  p_len_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(iss_q) < MAX_VL));

endmodule

// File: rtl/vec_stride_loader.sv
module vec_stride_loader #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int MEM_LAT   = 12,
  parameter int MAX_VL    = 64,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int LEN_W     = $clog2(MAX_VL + 1),
  parameter int IDX_W     = $clog2(MAX_VL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [ADDR_W-1:0]        cmd_base,
  input  logic [ADDR_W-1:0]        cmd_stride,
  input  logic [LEN_W-1:0]         cmd_vlen,
  output logic                     mem_req_valid,
  output logic [BANK_W-1:0]        mem_req_bank,
  output logic [ADDR_W-BANK_W-1:0] mem_req_row,
  input  logic [DATA_W-1:0]        mem_rd_data,
  output logic                     vreg_we,
  output logic [IDX_W-1:0]         vreg_idx,
  output logic [DATA_W-1:0]        vreg_data,
  output logic                     done
);

  logic [NUM_BANKS-1:0] bank_busy;
  logic                 idle;
  logic                 issue;
  logic [ADDR_W-1:0]    issue_addr;
  logic [IDX_W-1:0]     issue_idx;
  logic                 ret_valid;
  logic [IDX_W-1:0]     ret_idx;

  vsl_addr_gen #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MAX_VL(MAX_VL),
    .LEN_W(LEN_W), .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .bank_busy(bank_busy), .wr_fire(ret_valid), .wr_idx(ret_idx),
    .idle(idle), .req_valid(issue), .req_addr(issue_addr), .req_idx(issue_idx),
    .done(done)
  );

  vsl_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BUSY(BANK_BUSY), .BANK_W(BANK_W)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .claim_valid(issue), .claim_bank(issue_addr[BANK_W-1:0]),
    .busy_vec(bank_busy)
  );

  vsl_return_track #(
    .MEM_LAT(MEM_LAT), .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .push_valid(issue), .push_idx(issue_idx),
    .pop_valid(ret_valid), .pop_idx(ret_idx)
  );

  assign cmd_ready     = idle;
  assign mem_req_valid = issue;
  assign mem_req_bank  = issue_addr[BANK_W-1:0];
  assign mem_req_row   = issue_addr[ADDR_W-1:BANK_W];
  assign vreg_we       = ret_valid;
  assign vreg_idx      = ret_idx;
  assign vreg_data     = mem_rd_data;

  // R5: element writes only happen while a load is outstanding
  p_write_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_we |-> !idle);

  // R3: a request and completion never share a cycle
  p_no_req_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid);

endmodule

// File: tb/vec_stride_loader_test.sv
`timescale 1ns/1ps
module vec_stride_loader_test;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NB     = 16;
  localparam int BUSY   = 4;
  localparam int LAT    = 12;
  localparam int MAXVL  = 64;
  localparam int LEN_W  = 7;
  localparam int IDX_W  = 6;
  localparam int NCMD   = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [ADDR_W-1:0] cmd_stride = '0;
  logic [LEN_W-1:0]  cmd_vlen = '0;
  logic              mem_req_valid;
  logic [3:0]        mem_req_bank;
  logic [ADDR_W-5:0] mem_req_row;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic              vreg_we;
  logic [IDX_W-1:0]  vreg_idx;
  logic [DATA_W-1:0] vreg_data;
  logic              done;

  vec_stride_loader uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .mem_req_valid(mem_req_valid), .mem_req_bank(mem_req_bank), .mem_req_row(mem_req_row),
    .mem_rd_data(mem_rd_data),
    .vreg_we(vreg_we), .vreg_idx(vreg_idx), .vreg_data(vreg_data),
    .done(done)
  );

  always #2.5 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  // command program
  logic [31:0] c_base   [NCMD];
  logic [31:0] c_stride [NCMD];
  int          c_len    [NCMD];

  initial begin
    c_base[0] = 32'h100;      c_stride[0] = 32'd1;         c_len[0] = 20;
    c_base[1] = 32'h40;       c_stride[1] = 32'd16;        c_len[1] = 6;
    c_base[2] = 32'h7;        c_stride[2] = 32'hFFFFFFFF;  c_len[2] = 10;
    c_base[3] = 32'h5;        c_stride[3] = 32'd2;         c_len[3] = 12;
    c_base[4] = 32'h3;        c_stride[4] = 32'd8;         c_len[4] = 8;
    c_base[5] = 32'h9;        c_stride[5] = 32'd0;         c_len[5] = 4;
    c_base[6] = 32'h20;       c_stride[6] = 32'd5;         c_len[6] = 0;
    c_base[7] = 32'hFFFFFFF0; c_stride[7] = 32'd3;         c_len[7] = 70;
    c_base[8] = 32'h1000;     c_stride[8] = 32'd4;         c_len[8] = 16;
    c_base[9] = 32'h33;       c_stride[9] = 32'd32;        c_len[9] = 5;
  end

  // bench memory
  typedef struct { longint due; logic [31:0] addr; } mrec_t;
  mrec_t mq[$];

  // reference model
  typedef struct { longint due; int idx; logic [31:0] addr; } wrec_t;
  wrec_t       wq[$];
  bit          m_act = 1'b0;
  logic [31:0] m_addr, m_stride;
  int          m_len, m_iss, m_wr;
  longint      bank_free [NB];
  longint      done_at = -1;
  int          cur_cmd = -1;
  longint      last_iss = -1;
  int          writes_in_cmd = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      wrap_up();
    end
  end

  initial begin
    longint t;
    int     ptr;
    int     tail;
    bit     exp_req, exp_we, exp_done;
    int     eb;
    logic [31:0] ea;
    for (int b = 0; b < NB; b++) bank_free[b] = 0;

    // R9: outputs while reset is held
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "cmd_ready in reset", cmd_ready, 1);
    chk(mem_req_valid == 1'b0, "R9", "req in reset", mem_req_valid, 0);
    chk(vreg_we == 1'b0, "R9", "we in reset", vreg_we, 0);
    chk(done == 1'b0, "R9", "done in reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;

    t = 0;
    ptr = 0;
    tail = 0;
    while (tail < 6) begin
      // memory return for this cycle
      if (mq.size() > 0 && mq[0].due == t) begin
        mem_rd_data = mem_word(mq[0].addr);
        void'(mq.pop_front());
      end else begin
        mem_rd_data = 32'hBAD00000 ^ 32'(t);
      end
      // command drive
      if (!m_act && ptr < NCMD) begin
        cmd_valid  = 1'b1;
        cmd_base   = c_base[ptr];
        cmd_stride = c_stride[ptr];
        cmd_vlen   = LEN_W'(c_len[ptr]);
      end else if (m_act && (t % 3 == 0)) begin
        // R1: stray command during a load
        cmd_valid  = 1'b1;
        cmd_base   = 32'h5555;
        cmd_stride = 32'd7;
        cmd_vlen   = 7'd3;
      end else begin
        cmd_valid = 1'b0;
      end
      #1;

      // expected outputs for cycle t
      ea = m_addr;
      eb = int'(ea[3:0]);
      exp_req  = m_act && (m_iss < m_len) && (bank_free[eb] <= t);
      exp_we   = (wq.size() > 0) && (wq[0].due == t);
      exp_done = (done_at == t);

      chk(cmd_ready == !m_act, "R1", "cmd_ready", cmd_ready, !m_act);
      chk(mem_req_valid == exp_req, "R4", "mem_req_valid", mem_req_valid, exp_req);
      if (exp_req && mem_req_valid) begin
        chk(mem_req_bank == ea[3:0], "R2", "mem_req_bank", mem_req_bank, ea[3:0]);
        chk(mem_req_row == ea[31:4], "R2", "mem_req_row", mem_req_row, ea[31:4]);
      end
      chk(vreg_we == exp_we, "R5", "vreg_we", vreg_we, exp_we);
      if (exp_we && vreg_we) begin
        chk(int'(vreg_idx) == wq[0].idx, "R5", "vreg_idx", vreg_idx, wq[0].idx);
        chk(vreg_data == mem_word(wq[0].addr), "R5", "vreg_data", vreg_data, mem_word(wq[0].addr));
      end
      if (cur_cmd == 6)
        chk(done == exp_done, "R7", "done for empty load", done, exp_done);
      else
        chk(done == exp_done, "R6", "done", done, exp_done);

      // bench memory sees the request
      if (mem_req_valid) begin
        mrec_t r;
        r.due  = t + LAT;
        r.addr = {mem_req_row, mem_req_bank};
        mq.push_back(r);
        // R4: same-bank stride paces at the bank occupancy
        if (cur_cmd == 1 && last_iss >= 0)
          chk(t - last_iss == BUSY, "R4", "stride-16 spacing", t - last_iss, BUSY);
        // R3: unit stride issues back to back
        if (cur_cmd == 0 && last_iss >= 0)
          chk(t - last_iss == 1, "R3", "unit-stride spacing", t - last_iss, 1);
        last_iss = t;
      end

      // model update at the edge ending cycle t
      if (exp_req) begin
        wrec_t w;
        bank_free[eb] = t + BUSY;
        w.due  = t + LAT;
        w.idx  = m_iss;
        w.addr = m_addr;
        wq.push_back(w);
        m_addr = m_addr + m_stride;
        m_iss++;
      end
      if (exp_we) begin
        void'(wq.pop_front());
        m_wr++;
        writes_in_cmd++;
        if (m_wr == m_len) begin
          m_act = 1'b0;
          done_at = t + 1;
          // R8: oversize count clamped to capacity
          if (cur_cmd == 7)
            chk(writes_in_cmd == MAXVL, "R8", "clamped element count", writes_in_cmd, MAXVL);
        end
      end
      if (cmd_valid && !m_act && !(exp_we && m_wr == m_len && m_len != 0 && done_at == t + 1)) begin
        int n;
        n = (int'(cmd_vlen) > MAXVL) ? MAXVL : int'(cmd_vlen);
        cur_cmd = ptr;
        ptr++;
        last_iss = -1;
        writes_in_cmd = 0;
        if (n == 0) begin
          done_at = t + 1;
        end else begin
          m_act    = 1'b1;
          m_addr   = cmd_base;
          m_stride = cmd_stride;
          m_len    = n;
          m_iss    = 0;
          m_wr     = 0;
        end
      end

      if (ptr == NCMD && !m_act && wq.size() == 0 && t > done_at) tail++;
      @(negedge clk);
      t++;
    end
    wrap_up();
  end

endmodule